// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block collects interrupt events for a small 8-bit core. A one-cycle strobe from an external pin or a timer sets a sticky pending flag. Each flag is gated by its own enable bit and by one global enable bit. When any source is both pending and enabled while the global enable is on, the block raises an interrupt request. It also presents the vector index of the most urgent pending source.

Software reaches the global enable, two mask bytes and two flag bytes through a byte-wide register port. Flags are cleared by writing a one to their bit. A read-modify-write that copies back a flag byte with one bit changed therefore clears every flag that was read as set.

The core pulses an entry strobe when it takes the interrupt. This strobe turns the global enable off and clears the winning flag in the same cycle. A return strobe turns the global enable back on.

Top module: `irqc_ctrl`

## Requirements
- R1: After reset all flags, mask bits and the global enable are zero, every register reads 0x00, `irq_o` is 0 and `vec_o` is 0.
- R2: A one-cycle pulse on `evt_i[i]` sets flag i, which is visible one cycle later. Source order and flag bit positions are: 0 = ext pin A (addr 2, bit 6), 1 = ext pin B (addr 2, bit 7), 2 = timer-1 capture (addr 4, bit 3), 3 = timer-1 compare (addr 4, bit 6), 4 = timer-1 overflow (addr 4, bit 7), 5 = timer-0 overflow (addr 4, bit 1).
- R3: Writing a flag register clears every flag whose data bit is 1 and leaves a flag unchanged where the data bit is 0.
- R4: An event strobe wins over a clear in the same cycle, whether the clear comes from a one-write or from interrupt entry, so the flag stays set.
- R5: `irq_o` is 1 exactly when the global enable is 1 and at least one source has both its flag and its mask bit set.
- R6: `vec_o` equals 1 + the lowest source index that is pending and enabled, with lower index meaning higher priority. It is 0 when `irq_o` is 0.
- R7: A pulse on `ack_i` clears the global enable. If `irq_o` was 1 in that cycle, it also clears only the flag of the source named by `vec_o`.
- R8: A pulse on `reti_i` sets the global enable. If `ack_i` arrives in the same cycle, the enable is cleared instead.
- R9: The global enable is bit 7 of address 0 and is readable and writable by software. `ack_i` and `reti_i` override a same-cycle software write.
- R10: Mask bits sit in the same bit positions as their flags: address 1 for the external pins and address 3 for the timers.
- R11: Bits that hold no flag, mask or enable read 0 and ignore writes, and addresses 5 to 7 read 0x00.
- R12: Writing back a flag byte as read, with one further bit set, clears every flag that was read as set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data at `addr` |
| evt_i | input | 6 | Event strobes, one per source |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 3 | Vector index of the winning source, 0 when idle |
| ack_i | input | 1 | Interrupt entry strobe from the core |
| reti_i | input | 1 | Interrupt return strobe from the core |

## Verification
The priority logic is driven in three ways. All six sources are made pending at once and then retired one by one through the entry strobe, which must walk the vector from 1 to 6. A sparse pattern of two low-priority sources shows that the lowest pending index wins and not simply the lowest set bit of a register. A pattern with pending flags but masks or the global enable off separates gating from flag storage. The collision cases put an event strobe in the same cycle as a one-write and as an entry strobe, which tells the set-priority rule apart from the clear path. The read-modify-write case shows that a bit-set on a flag byte wipes out flags the program never meant to touch.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int N_SRC = 6;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int VW    = $clog2(N_SRC + 1);
    localparam int GIE_BIT = 7;

    typedef enum logic [AW-1:0] {
        A_GLB  = 3'd0,
        A_XMSK = 3'd1,
        A_XFLG = 3'd2,
        A_TMSK = 3'd3,
        A_TFLG = 3'd4
    } addr_e;

    // bit position of each source inside its mask/flag byte
    function automatic int src_bit(input int i);
        case (i)
            0: return 6;
            1: return 7;
            2: return 3;
            3: return 6;
            4: return 7;
            default: return 1;
        endcase
    endfunction

    // 1 when a source lives in the timer register pair
    function automatic bit src_tmr(input int i);
        return (i >= 2);
    endfunction

    typedef struct packed {
        logic gie;
    } glb_t;

    typedef struct packed {
        logic flag;
        logic mask;
    } cell_t;
endpackage

// File: rtl/irqc_src_cell.sv
module irqc_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic mask_we_i,
    input  logic mask_i,
    output logic flag_o,
    output logic mask_o
);
    import irqc_pkg::*;

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (mask_we_i) cell_d.mask = mask_i;
        if (clr_i)     cell_d.flag = 1'b0;
        if (set_i)     cell_d.flag = 1'b1;   // set beats clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end

    assign flag_o = cell_q.flag;
    assign mask_o = cell_q.mask;
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int N  = 6,
    parameter int VW = $clog2(N + 1)
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic [VW-1:0] vec_o
);
    always_comb begin
        grant_o = '0;
        vec_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                vec_o      = VW'(i + 1);
            end
        end
    end
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
    import irqc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic [N_SRC-1:0] evt_i,
    output logic          irq_o,
    output logic [VW-1:0] vec_o,
    input  logic          ack_i,
    input  logic          reti_i
);
    glb_t glb_d, glb_q;
    logic [N_SRC-1:0] flag_v, mask_v, grant;
    logic [N_SRC-1:0] req;

    assign req   = flag_v & mask_v & {N_SRC{glb_q.gie}};
    assign irq_o = |req;

    irqc_prio #(.N(N_SRC), .VW(VW)) u_prio (
        .req_i  (req),
        .grant_o(grant),
        .vec_o  (vec_o)
    );

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        localparam int  BP  = src_bit(i);
        localparam bit  TMR = src_tmr(i);
        localparam logic [AW-1:0] FA = TMR ? A_TFLG : A_XFLG;
        localparam logic [AW-1:0] MA = TMR ? A_TMSK : A_XMSK;
        logic clr, mwe;
        assign clr = (wr_en && addr == FA && wr_data[BP]) ||
                     (ack_i && irq_o && grant[i]);
        assign mwe = wr_en && addr == MA;
        irqc_src_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (evt_i[i]),
            .clr_i    (clr),
            .mask_we_i(mwe),
            .mask_i   (wr_data[BP]),
            .flag_o   (flag_v[i]),
            .mask_o   (mask_v[i])
        );
    end

    always_comb begin
        glb_d = glb_q;
        if (wr_en && addr == A_GLB) glb_d.gie = wr_data[GIE_BIT];
        if (reti_i)                 glb_d.gie = 1'b1;
        if (ack_i)                  glb_d.gie = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) glb_q <= '0;
        else        glb_q <= glb_d;
    end

    logic [DW-1:0] xm, xf, tm, tf;
    always_comb begin
        xm = '0; xf = '0; tm = '0; tf = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (src_tmr(i)) begin
                tm[src_bit(i)] = mask_v[i];
                tf[src_bit(i)] = flag_v[i];
            end else begin
                xm[src_bit(i)] = mask_v[i];
                xf[src_bit(i)] = flag_v[i];
            end
        end
        case (addr)
            A_GLB:   begin rd_data = '0; rd_data[GIE_BIT] = glb_q.gie; end
            A_XMSK:  rd_data = xm;
            A_XFLG:  rd_data = xf;
            A_TMSK:  rd_data = tm;
            A_TFLG:  rd_data = tf;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ack_i,
    input logic             reti_i,
    input logic [N_SRC-1:0] evt_i,
    input logic             irq_o,
    input logic [VW-1:0]    vec_o,
    input logic             gie,
    input logic [N_SRC-1:0] flags,
    input logic [N_SRC-1:0] grant
);
    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((flags & $past(evt_i)) == $past(evt_i))) else $error("evt"); // R2
    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> gie) else $error("gie"); // R5
    AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vec_o == '0)) else $error("vec"); // R6
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)) else $error("grant"); // R6
    AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !gie) else $error("ack"); // R7
    AST_RETI_RAISES_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !ack_i) |=> gie) else $error("reti"); // R8
endmodule

bind irqc_ctrl irqc_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ack_i (ack_i),
    .reti_i(reti_i),
    .evt_i (evt_i),
    .irq_o (irq_o),
    .vec_o (vec_o),
    .gie   (glb_q.gie),
    .flags (flag_v),
    .grant (grant)
);

// File: tb/tb_irqc_ctrl.sv
module tb_irqc_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [2:0] addr = 0;
    logic       wr_en = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic [5:0] evt_i = 0;
    logic       irq_o;
    logic [2:0] vec_o;
    logic       ack_i = 0;
    logic       reti_i = 0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .evt_i(evt_i),
        .irq_o(irq_o), .vec_o(vec_o), .ack_i(ack_i), .reti_i(reti_i)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    // inputs change 1 time unit after a rising edge
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1;
        step();
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; #1; d = rd_data;
    endtask

    task automatic pulse_evt(input logic [5:0] e);
        evt_i = e; step(); evt_i = 0;
    endtask

    task automatic clear_all();
        wr(3'd2, 8'hFF); wr(3'd4, 8'hFF);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d); chk($sformatf("R1 reg%0d", a), d, 0);
        end
        chk("R1 irq", irq_o, 0);
        chk("R1 vec", vec_o, 0);
    endtask

    task automatic t_events();
        logic [7:0] d;
        pulse_evt(6'b000001); rd(3'd2, d); chk("R2 ext A", d, 8'h40);
        pulse_evt(6'b111110);
        rd(3'd2, d); chk("R2 ext both", d, 8'hC0);
        rd(3'd4, d); chk("R2 timer", d, 8'hCA);
        wr(3'd4, 8'h00); rd(3'd4, d); chk("R3 zero write keeps", d, 8'hCA);
        wr(3'd4, 8'h48); rd(3'd4, d); chk("R3 partial clear", d, 8'h82);
        clear_all();
        rd(3'd2, d); chk("R3 ext cleared", d, 0);
        rd(3'd4, d); chk("R3 timer cleared", d, 0);
    endtask

    task automatic t_collision();
        logic [7:0] d;
        addr = 3'd4; wr_data = 8'h80; wr_en = 1; evt_i = 6'b010000;
        step(); wr_en = 0; evt_i = 0;
        rd(3'd4, d); chk("R4 event beats write", d, 8'h80);
        clear_all();
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(3'd1, 8'hFF); rd(3'd1, d); chk("R10 ext mask", d, 8'hC0);
        wr(3'd3, 8'hFF); rd(3'd3, d); chk("R10 timer mask", d, 8'hCA);
        wr(3'd3, 8'h08); rd(3'd3, d); chk("R10 timer mask single", d, 8'h08);
        wr(3'd0, 8'h7F); rd(3'd0, d); chk("R11 reserved glb bits", d, 0);
        wr(3'd5, 8'hFF); rd(3'd5, d); chk("R11 addr5", d, 0);
        rd(3'd2, d); chk("R11 flags untouched", d, 0);
        wr(3'd0, 8'h80); rd(3'd0, d); chk("R9 gie write", d, 8'h80);
        wr(3'd0, 8'h00); rd(3'd0, d); chk("R9 gie clear", d, 0);
    endtask

    task automatic t_gate();
        // timer mask holds only capture (source 2)
        pulse_evt(6'b100000);
        wr(3'd0, 8'h80); #1;
        chk("R5 masked source no irq", irq_o, 0);
        wr(3'd0, 8'h00);
        pulse_evt(6'b000100); #1;
        chk("R5 gie off no irq", irq_o, 0);
        wr(3'd0, 8'h80); #1;
        chk("R5 enabled irq", irq_o, 1);
        chk("R6 capture vec", vec_o, 3);
        wr(3'd0, 8'h00);
        clear_all();
    endtask

    task automatic t_sparse();
        wr(3'd3, 8'hFF); wr(3'd1, 8'hFF);
        pulse_evt(6'b101000);
        wr(3'd0, 8'h80); #1;
        chk("R6 sparse vec", vec_o, 4);
        wr(3'd0, 8'h00); clear_all();
    endtask

    task automatic t_walk();
        logic [7:0] d;
        pulse_evt(6'b111111);
        wr(3'd0, 8'h80);
        for (int k = 0; k < 6; k++) begin
            #1;
            chk($sformatf("R6 walk irq %0d", k), irq_o, 1);
            chk($sformatf("R6 walk vec %0d", k), vec_o, k + 1);
            ack_i = 1; step(); ack_i = 0;
            rd(3'd0, d); chk($sformatf("R7 gie off %0d", k), d, 0);
            chk($sformatf("R7 irq off %0d", k), irq_o, 0);
            if (k == 0) begin
                rd(3'd2, d); chk("R7 only winner cleared ext", d, 8'h80);
                rd(3'd4, d); chk("R7 timers kept", d, 8'hCA);
            end
            reti_i = 1; step(); reti_i = 0;
            rd(3'd0, d); chk($sformatf("R8 gie on %0d", k), d, 8'h80);
        end
        #1; chk("R6 walk done", irq_o, 0);
    endtask

    task automatic t_ack_evt();
        logic [7:0] d;
        pulse_evt(6'b000010); #1;
        chk("R4 pre vec", vec_o, 2);
        ack_i = 1; evt_i = 6'b000010; step(); ack_i = 0; evt_i = 0;
        rd(3'd2, d); chk("R4 event beats ack", d, 8'h80);
        addr = 3'd0; wr_data = 8'h80; wr_en = 1; ack_i = 1; reti_i = 1;
        step(); wr_en = 0; ack_i = 0; reti_i = 0;
        rd(3'd0, d); chk("R8 ack beats reti and write", d, 0);
        reti_i = 1; addr = 3'd0; wr_data = 8'h00; wr_en = 1;
        step(); reti_i = 0; wr_en = 0;
        rd(3'd0, d); chk("R9 reti beats write", d, 8'h80);
        wr(3'd0, 8'h00); clear_all();
    endtask

    task automatic t_rmw();
        logic [7:0] d;
        pulse_evt(6'b100001);
        rd(3'd2, d);
        wr(3'd2, d | 8'h01);
        rd(3'd2, d); chk("R12 rmw clears ext flags", d, 0);
        rd(3'd4, d); chk("R12 other register kept", d, 8'h02);
        clear_all();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        t_reset();
        t_events();
        t_collision();
        t_regs();
        t_gate();
        t_sparse();
        t_walk();
        t_ack_evt();
        t_rmw();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                fails++; checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule